// File: doc/BRIEF.md
# Eight-Channel Periodic Timer

This block generates periodic events on eight independent channels. Each channel owns a 16-bit down-counter and a 16-bit reload value. Two shared 8-bit prescalers divide the system clock into two tick streams, and every channel picks one of them through its own select bit. When a counter runs down to zero, the channel raises a timeout flag and reloads on the following tick, so it keeps firing at a fixed period. A flag drives the channel's interrupt line when that channel's interrupt enable is set.

Software reaches the block through a small synchronous byte bus. It has a global run bit, per-channel enables, per-channel tick-source selects and per-channel interrupt enables. It also has a write-one-to-clear flag register, write-one force-reload strobes, the prescaler reload values, the channel reload values and read-only views of the live counters. The read data is combinational from the current address.

Top module: `ptmr_top`

## Requirements
- R1: After reset, every register, every counter, the flags and all `irq` bits read zero.
- R2: Register map (byte addresses): 0x00 control (bit 0 = run), 0x01 force strobes, 0x02 channel enables, 0x03 tick-source selects, 0x04 interrupt enables, 0x05 flags, 0x06 prescaler 0 reload, 0x07 prescaler 1 reload, 0x08+2n / 0x09+2n low / high byte of channel n reload, 0x18+2n / 0x19+2n low / high byte of channel n counter (read-only). Writable registers read back what was written, and unused addresses read zero.
- R3: While run is set, prescaler p pulses its tick once every (reload+1) clock cycles. While run is clear, it holds its reload value and does not tick.
- R4: A channel whose select bit is 0 counts on prescaler 0 ticks. A channel whose select bit is 1 counts on prescaler 1 ticks.
- R5: On the first clock after a channel becomes active (run and its enable both set), its counter is loaded with its reload value.
- R6: On each selected tick, an active channel decrements its counter. The tick that takes the counter to zero sets the flag. The next tick reloads the counter. With a reload of zero, the counter stays at zero and the flag is set on every tick.
- R7: Writing 1 to a bit of the force register loads that channel's counter from its reload value at the write clock, but only if the channel is active. Bits written 0, and bits of inactive channels, have no effect. The force register reads zero.
- R8: Writing 1 to a flag bit clears it. A timeout in the same cycle wins over the clear.
- R9: Clearing a channel's enable clears its flag and freezes its counter.
- R10: Clearing run stops both prescalers and all counters and clears all flags.
- R11: `irq[n]` equals flag n ANDed with interrupt enable n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 8 | Per-channel interrupt request |

## Verification
Read data reflects the register state in the same cycle the address is presented. A write becomes visible on the clock edge that takes it. A force strobe reloads the counter at that same edge. A channel enable produces its start load one edge after the enable itself is stored. A prescaler tick is a combinational pulse in the cycle its count sits at zero, and the counter moves on the edge closing that cycle. The bench drives inputs 2 ns after each rising edge and steps a behavioural model at every rising edge. At every falling edge it compares `irq` and the read data of a rotating address against the model, so each of these latencies is checked exactly in the cycle it is due.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int DW      = 8;
  localparam int A_CTRL  = 'h00;
  localparam int A_FRC   = 'h01;
  localparam int A_CHEN  = 'h02;
  localparam int A_SEL   = 'h03;
  localparam int A_IEN   = 'h04;
  localparam int A_FLAG  = 'h05;
  localparam int A_PRE0  = 'h06;
  localparam int A_PRE1  = 'h07;
  localparam int A_LD    = 'h08;
  localparam int NSRC    = 2;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] load,
  output logic          tick
);
  logic [PW-1:0] cnt;

  function automatic logic [PW-1:0] pre_next(input logic r, input logic [PW-1:0] c,
                                             input logic [PW-1:0] l);
    if (!r || c == '0) return l;
    return c - 1'b1;
  endfunction

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= pre_next(run, cnt, load);
  end

  // R3: a non-zero reload leaves at least one idle cycle between ticks
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && load != '0) |=> !tick);
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int PW  = 8,
  parameter int AW  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  input  logic                    we,
  input  logic [NCH-1:0]          flag,
  input  logic [NCH-1:0][CW-1:0]  cnt,
  output logic                    men,
  output logic [NCH-1:0]          chen,
  output logic [NCH-1:0]          sel,
  output logic [NCH-1:0]          ien,
  output logic [NSRC-1:0][PW-1:0] pld,
  output logic [NCH-1:0][CW-1:0]  ld,
  output logic [NCH-1:0]          frc_stb,
  output logic [NCH-1:0]          clr_stb,
  output logic [DW-1:0]           rdata
);
  localparam int NB     = CW / DW;
  localparam int A_CNT  = A_LD + NCH * NB;

  function automatic logic hit(input logic [AW-1:0] a, input int target);
    return a == AW'(target);
  endfunction

  assign frc_stb = (we && hit(addr, A_FRC))  ? wdata[NCH-1:0] : '0;
  assign clr_stb = (we && hit(addr, A_FLAG)) ? wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men  <= 1'b0;
      chen <= '0;
      sel  <= '0;
      ien  <= '0;
      pld  <= '0;
      ld   <= '0;
    end else if (we) begin
      if (hit(addr, A_CTRL)) men  <= wdata[0];
      if (hit(addr, A_CHEN)) chen <= wdata[NCH-1:0];
      if (hit(addr, A_SEL))  sel  <= wdata[NCH-1:0];
      if (hit(addr, A_IEN))  ien  <= wdata[NCH-1:0];
      if (hit(addr, A_PRE0)) pld[0] <= wdata[PW-1:0];
      if (hit(addr, A_PRE1)) pld[1] <= wdata[PW-1:0];
      for (int c = 0; c < NCH; c++) begin
        for (int b = 0; b < NB; b++) begin
          if (hit(addr, A_LD + c * NB + b)) ld[c][b*DW +: DW] <= wdata;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit(addr, A_CTRL)) rdata = DW'(men);
    if (hit(addr, A_CHEN)) rdata = DW'(chen);
    if (hit(addr, A_SEL))  rdata = DW'(sel);
    if (hit(addr, A_IEN))  rdata = DW'(ien);
    if (hit(addr, A_FLAG)) rdata = DW'(flag);
    if (hit(addr, A_PRE0)) rdata = DW'(pld[0]);
    if (hit(addr, A_PRE1)) rdata = DW'(pld[1]);
    for (int c = 0; c < NCH; c++) begin
      for (int b = 0; b < NB; b++) begin
        if (hit(addr, A_LD + c * NB + b))  rdata = ld[c][b*DW +: DW];
        if (hit(addr, A_CNT + c * NB + b)) rdata = cnt[c][b*DW +: DW];
      end
    end
  end

  // R7: the strobe register never returns data
  assert_frc_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit(addr, A_FRC) |-> rdata == '0);
  // R2: a channel-enable write is stored for the next cycle
  assert_chen_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit(addr, A_CHEN)) |=> chen == $past(wdata[NCH-1:0]));
endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
  import ptmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            men,
  input  logic            chen,
  input  logic            sel,
  input  logic [NSRC-1:0] ticks,
  input  logic [CW-1:0]   ld,
  input  logic            frc_req,
  input  logic            clr_req,
  output logic [CW-1:0]   cnt,
  output logic            flag
);
  logic active, active_q, start_evt, frc_evt, load_evt, step_evt, timeout;

  function automatic logic [CW-1:0] count_next(input logic [CW-1:0] c, input logic [CW-1:0] l);
    return (c == '0) ? l : c - 1'b1;
  endfunction

  function automatic logic reaches_zero(input logic [CW-1:0] c, input logic [CW-1:0] l);
    return (c == CW'(1)) || (c == '0 && l == '0);
  endfunction

  assign active    = men && chen;
  assign start_evt = active && !active_q;
  assign frc_evt   = active && frc_req;
  assign load_evt  = start_evt || frc_evt;
  assign step_evt  = active && ticks[sel] && !load_evt;
  assign timeout   = step_evt && reaches_zero(cnt, ld);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      flag     <= 1'b0;
      active_q <= 1'b0;
    end else begin
      active_q <= active;
      if (load_evt)      cnt <= ld;
      else if (step_evt) cnt <= count_next(cnt, ld);
      if (!active)       flag <= 1'b0;
      else if (timeout)  flag <= 1'b1;
      else if (clr_req)  flag <= 1'b0;
    end
  end

  assert_start_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> cnt == $past(ld));
  assert_force_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frc_evt |=> cnt == $past(ld));
  assert_timeout_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> flag);
  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !timeout) |=> !flag);
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chen |=> !flag);
  assert_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> cnt == $past(cnt));
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 16,
  parameter int PW  = 8,
  parameter int AW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic [DW-1:0] bus_rdata,
  output logic [NCH-1:0] irq
);
  logic                    men;
  logic [NCH-1:0]          chen, sel, ien, frc_stb, clr_stb, flag;
  logic [NSRC-1:0][PW-1:0] pld;
  logic [NCH-1:0][CW-1:0]  ld, cnt;
  logic [NSRC-1:0]         ticks;

  ptmr_regs #(.NCH(NCH), .CW(CW), .PW(PW), .AW(AW)) u_regs (
    .clk, .rst_n, .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .flag, .cnt, .men, .chen, .sel, .ien, .pld, .ld,
    .frc_stb, .clr_stb, .rdata(bus_rdata)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_pre
    ptmr_prescale #(.PW(PW)) u_pre (
      .clk, .rst_n, .run(men), .load(pld[g]), .tick(ticks[g])
    );
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    ptmr_channel #(.CW(CW)) u_ch (
      .clk, .rst_n, .men, .chen(chen[n]), .sel(sel[n]), .ticks,
      .ld(ld[n]), .frc_req(frc_stb[n]), .clr_req(clr_stb[n]),
      .cnt(cnt[n]), .flag(flag[n])
    );
  end

  assign irq = flag & ien;

  // R10: with run clear no interrupt survives into the next cycle
  assert_quiet_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !men |=> irq == '0);
  // R11: a masked channel never requests
  assert_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> irq == '0);
endmodule

// File: tb/sim_ptmr_top.sv
module sim_ptmr_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic [7:0] irq;

  always #5 clk = ~clk;

  ptmr_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_rdata(rdata), .irq(irq)
  );

  int vectors = 0, errors = 0, cycles = 0, rot = 0;
  bit cmp_en = 0, done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_men, m_pld[2], m_pcnt[2], m_ld[8], m_cnt[8];
  bit [7:0] m_chen, m_sel, m_ien, m_flag, m_actq;

  function automatic int model_rd(int a);
    if (a == 0) return m_men;
    if (a == 2) return m_chen;
    if (a == 3) return m_sel;
    if (a == 4) return m_ien;
    if (a == 5) return m_flag;
    if (a == 6) return m_pld[0];
    if (a == 7) return m_pld[1];
    if (a >= 8 && a < 24)  return (m_ld[(a-8)/2]   >> (8*((a-8)%2)))  & 255;
    if (a >= 24 && a < 40) return (m_cnt[(a-24)/2] >> (8*((a-24)%2))) & 255;
    return 0;
  endfunction

  task automatic model_reset();
    m_men = 0; m_chen = 0; m_sel = 0; m_ien = 0; m_flag = 0; m_actq = 0;
    for (int i = 0; i < 2; i++) begin m_pld[i] = 0; m_pcnt[i] = 0; end
    for (int i = 0; i < 8; i++) begin m_ld[i] = 0; m_cnt[i] = 0; end
  endtask

  task automatic model_step();
    bit tk[2];
    int npc[2], ncnt[8];
    bit [7:0] nflag, nact;
    for (int p = 0; p < 2; p++) begin
      tk[p]  = (m_men != 0) && (m_pcnt[p] == 0);
      npc[p] = (m_men == 0 || m_pcnt[p] == 0) ? m_pld[p] : m_pcnt[p] - 1;
    end
    nflag = m_flag;
    for (int i = 0; i < 8; i++) begin
      bit act, st, fr, t, to, clr;
      act = (m_men != 0) && m_chen[i];
      st  = act && !m_actq[i];
      fr  = act && we && addr == 1 && wdata[i];
      clr = we && addr == 5 && wdata[i];
      t   = m_sel[i] ? tk[1] : tk[0];
      ncnt[i] = m_cnt[i];
      to = 0;
      if (st || fr) ncnt[i] = m_ld[i];
      else if (act && t) begin
        ncnt[i] = (m_cnt[i] == 0) ? m_ld[i] : m_cnt[i] - 1;
        to = (m_cnt[i] == 1) || (m_cnt[i] == 0 && m_ld[i] == 0);
      end
      if (!act)     nflag[i] = 0;
      else if (to)  nflag[i] = 1;
      else if (clr) nflag[i] = 0;
      nact[i] = act;
    end
    m_pcnt = npc; m_cnt = ncnt; m_flag = nflag; m_actq = nact;
    if (we) begin
      case (int'(addr))
        0: m_men  = wdata[0];
        2: m_chen = wdata;
        3: m_sel  = wdata;
        4: m_ien  = wdata;
        6: m_pld[0] = wdata;
        7: m_pld[1] = wdata;
        default:
          if (addr >= 8 && addr < 24) begin
            if (addr[0]) m_ld[(addr-8)/2] = (m_ld[(addr-8)/2] & 255) | (int'(wdata) << 8);
            else         m_ld[(addr-8)/2] = (m_ld[(addr-8)/2] & 'hFF00) | int'(wdata);
          end
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      vectors++;
      if (int'(rdata) != model_rd(int'(addr))) begin
        errors++;
        $display("FAIL %s addr=%0h rdata actual=%0h expected=%0h", cur_req, addr, rdata, model_rd(int'(addr)));
      end
      vectors++;
      if (irq !== (m_flag & m_ien)) begin
        errors++;
        $display("FAIL %s/R11 irq actual=%0h expected=%0h", cur_req, irq, m_flag & m_ien);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog (all R) actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #2;
    we = 1; addr = 6'(a); wdata = 8'(d);
    @(posedge clk); #2;
    we = 0;
  endtask

  task automatic wld(int ch, int v);
    wr(8 + 2*ch, v & 255);
    wr(9 + 2*ch, (v >> 8) & 255);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #2;
      we = 0; addr = 6'(rot); rot = (rot + 1) % 41;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cmp_en = 1;
    cur_req = "R1";  idle(45);
    cur_req = "R2";
    wr(4, 'hA5); wr(3, 'h5A); wr(6, 3); wr(7, 7);
    for (int i = 0; i < 8; i++) wld(i, 4 + 3*i);
    wld(7, 'h0102);
    idle(45);
    wr(4, 'hFF); wr(3, 'h00);
    cur_req = "R3";  wr(0, 1); idle(30);
    cur_req = "R5";  wr(2, 'h01); idle(6);
    cur_req = "R6";  idle(80);
    cur_req = "R4";  wr(3, 'h02); wr(2, 'h03); idle(100);
    cur_req = "R8";
    for (int k = 0; k < 6; k++) begin wr(5, 'hFF); idle(7); end
    cur_req = "R7";
    wr(1, 'h03); idle(3); wr(1, 'h00); idle(3); wr(1, 'h80); idle(10);
    wr(1, 'h01); idle(20);
    cur_req = "R6";  wld(2, 0); wr(2, 'h07); idle(30);
    cur_req = "R11"; wr(4, 'h01); idle(30); wr(4, 'h06); idle(20);
    cur_req = "R9";  wr(2, 'h06); idle(25);
    cur_req = "R10"; wr(0, 0); idle(20); wr(0, 1); idle(40);
    cur_req = "R3";  wr(6, 0); wr(7, 1); idle(40);
    done = 1;
    summary();
    $finish;
  end
endmodule